// File: doc/BRIEF.md
# Switch-Addressed Four-Byte I/O Output Port

This block is a 32-bit parallel output port for an 8-bit I/O bus of the ISA style. It watches the bus for I/O writes. It compares address bits 15 to 2 of each write with a base address set on switch inputs. When they match, the data byte goes into one of four byte registers, and address bits 1 and 0 pick which one. The four registers together drive the 32-bit output. Because the base address comes from switches, a card built around this block can be moved to another address so that it does not clash with other cards on the same bus.

The bus signals are sampled with the block's own clock. The write strobe is synchronized, and the write is committed on its trailing (rising) edge. Address, data and the DMA-cycle flag are captured while the strobe is low, so values that change after the strobe rises have no effect. A write made while the bus reports a DMA cycle is not decoded as an I/O write.

Top module: `iop_out_port`

## Requirements
- R1: After reset, all 32 bits of `port_q` are zero.
- R2: A write is accepted when `bus_dma_n` is high and `bus_addr[15:2]` equals `base_sw[13:0]`. Lane n, where n = `bus_addr[1:0]`, then holds the data byte on `port_q[8n+7:8n]`, so lane 0 is `port_q[7:0]`.
- R3: An accepted write changes only its own lane. The other three lanes keep their values, and `port_q` does not change while no write is being committed.
- R4: A write whose `bus_addr[15:2]` differs from `base_sw` leaves `port_q` unchanged.
- R5: A write made while `bus_dma_n` is low (a DMA cycle) leaves `port_q` unchanged, even when the address matches.
- R6: The write takes effect on the rising edge of `bus_wr_n`. While the strobe is held low, `port_q` keeps its old value. The new value shows on `port_q` within four clock cycles after the strobe rises.
- R7: The address, data and DMA flag used are those present while `bus_wr_n` was low. Values driven after the strobe rises do not change the result.
- R8: A new value on `base_sw` moves the port. After the change, writes are accepted at the new base and ignored at the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O address from the bus |
| bus_data | input | 8 | Write data byte from the bus |
| bus_wr_n | input | 1 | I/O write strobe, active low |
| bus_dma_n | input | 1 | Low while the bus runs a DMA cycle |
| base_sw | input | 14 | Switch setting for address bits 15 to 2 |
| port_q | output | 32 | Four byte lanes of the parallel output |

## Verification
The bench aims at the cases where a decoder most often goes wrong. An address that differs from the base in a single bit must be rejected. A design that drops part of the compare would accept it. A matching write made during a DMA cycle must be ignored, and a design that does not look at the DMA flag would write the byte. While the strobe is still low the output is checked for an early update, which catches a design that commits on the leading edge. After the strobe rises, the address and data are scrambled, which catches a design that samples the bus too late. The bench also changes the switch setting and writes to all four lanes, so swapped lanes or a stale base show up as a wrong byte.

// File: rtl/iop_pkg.sv
package iop_pkg;
  // Default bus geometry shared by the port and its bench
  localparam int unsigned IOP_ADDR_W = 16;
  localparam int unsigned IOP_SEL_W  = 2;
  localparam int unsigned IOP_DATA_W = 8;
endpackage

// File: rtl/iop_strobe_sync.sv
module iop_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n_i,
  output logic commit_o
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = wr_n_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  // trailing edge of the strobe: low last cycle, high now
  assign commit_o = s2_q & ~prev_q;

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/iop_addr_match.sv
module iop_addr_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned BASE_W = ADDR_W - SEL_W,
  localparam int unsigned LANES  = 1 << SEL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              dma_n_i,
  output logic              addr_ok_o,
  output logic              hit_o,
  output logic [LANES-1:0]  lane_oh_o
);
  always_comb begin
    addr_ok_o = (addr_i[ADDR_W-1:SEL_W] == base_i);
    hit_o     = addr_ok_o & dma_n_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
    assign lane_oh_o[g] = (addr_i[SEL_W-1:0] == SEL_W'(g));
  end
endmodule

// File: rtl/iop_lane_bank.sv
module iop_lane_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned OUT_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [OUT_W-1:0]  q_o
);
  // R3
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_i));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q, lane_d;

    always_comb begin
      lane_d = lane_q;
      if (we_i[g]) lane_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign q_o[g*DATA_W +: DATA_W] = lane_q;

    // R2
    lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[g] |=> (q_o[g*DATA_W +: DATA_W] == $past(d_i)));
  end
endmodule

// File: rtl/iop_out_port.sv
module iop_out_port
  import iop_pkg::*;
#(
  parameter int unsigned ADDR_W = IOP_ADDR_W,
  parameter int unsigned SEL_W  = IOP_SEL_W,
  parameter int unsigned DATA_W = IOP_DATA_W,
  localparam int unsigned BASE_W = ADDR_W - SEL_W,
  localparam int unsigned LANES  = 1 << SEL_W,
  localparam int unsigned OUT_W  = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_wr_n,
  input  logic              bus_dma_n,
  input  logic [BASE_W-1:0] base_sw,
  output logic [OUT_W-1:0]  port_q
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // bus capture while the strobe is low
  logic [ADDR_W-1:0] hold_addr_q, hold_addr_d;
  logic [DATA_W-1:0] hold_data_q, hold_data_d;
  logic              hold_dma_n_q, hold_dma_n_d;
  logic              cap_en;

  always_comb begin
    cap_en       = ~bus_wr_n;
    hold_addr_d  = hold_addr_q;
    hold_data_d  = hold_data_q;
    hold_dma_n_d = hold_dma_n_q;
    if (cap_en) begin
      hold_addr_d  = bus_addr;
      hold_data_d  = bus_data;
      hold_dma_n_d = bus_dma_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      hold_addr_q  <= '0;
      hold_data_q  <= '0;
      hold_dma_n_q <= 1'b1;
    end else begin
      hold_addr_q  <= hold_addr_d;
      hold_data_q  <= hold_data_d;
      hold_dma_n_q <= hold_dma_n_d;
    end
  end

  logic             commit;
  logic             addr_ok, hit;
  logic [LANES-1:0] lane_oh, lane_we;

  iop_strobe_sync i_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_n_i   (bus_wr_n),
    .commit_o (commit)
  );

  iop_addr_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_match (
    .addr_i    (hold_addr_q),
    .base_i    (base_sw),
    .dma_n_i   (hold_dma_n_q),
    .addr_ok_o (addr_ok),
    .hit_o     (hit),
    .lane_oh_o (lane_oh)
  );

  assign lane_we = lane_oh & {LANES{commit & hit}};

  iop_lane_bank #(.DATA_W(DATA_W), .LANES(LANES)) i_bank (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we_i  (lane_we),
    .d_i   (hold_data_q),
    .q_o   (port_q)
  );

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !commit |=> $stable(port_q));
  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (commit && !addr_ok) |=> $stable(port_q));
  // R5
  dma_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (commit && !hold_dma_n_q) |=> $stable(port_q));
endmodule

// File: tb/test_iop_out_port.sv
module test_iop_out_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        bus_wr_n;
  logic        bus_dma_n;
  logic [13:0] base_sw;
  logic [31:0] port_q;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_q;

  always #(CLK_P/2) clk = ~clk;

  iop_out_port i_iop_out_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr_n(bus_wr_n), .bus_dma_n(bus_dma_n), .base_sw(base_sw),
    .port_q(port_q)
  );

  function automatic logic [31:0] model_write(logic [31:0] cur, logic [15:0] a,
                                              logic [7:0] d, logic dma_n,
                                              logic [13:0] base);
    logic [31:0] r = cur;
    if (dma_n && a[15:2] == base) r[a[1:0]*8 +: 8] = d;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: port_q=%h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one bus write; after the strobe rises the bus is scrambled (R7)
  task automatic io_write(logic [15:0] a, logic [7:0] d, logic dma_n, string req);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_dma_n = dma_n;
    bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", port_q, exp_q);          // no early update while strobe low
    bus_wr_n = 1'b1;
    bus_addr = 16'($urandom); bus_data = 8'($urandom); bus_dma_n = 1'($urandom);
    repeat (5) @(negedge clk);
    exp_q = model_write(exp_q, a, d, dma_n, base_sw);
    check(req, port_q, exp_q);
    bus_dma_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: port_q=%h expected %h", port_q, exp_q);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1a7e));
    rst_n = 1'b0; bus_addr = '0; bus_data = '0; bus_wr_n = 1'b1;
    bus_dma_n = 1'b1; base_sw = 14'h00C0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", port_q, 32'h0);

    // R2 each lane directly
    io_write({base_sw, 2'd0}, 8'hA1, 1'b1, "R2");
    io_write({base_sw, 2'd1}, 8'hB2, 1'b1, "R2");
    io_write({base_sw, 2'd2}, 8'hC3, 1'b1, "R2");
    io_write({base_sw, 2'd3}, 8'hD4, 1'b1, "R2");
    check("R2", port_q, 32'hD4C3B2A1);
    // R3 rewrite one lane, others keep
    io_write({base_sw, 2'd1}, 8'h5E, 1'b1, "R3");
    check("R3", port_q, 32'hD4C3_5EA1);
    // R4 single-bit address misses
    for (int b = 0; b < 14; b++)
      io_write({base_sw ^ (14'd1 << b), 2'(b)}, 8'hFF, 1'b1, "R4");
    check("R4", port_q, 32'hD4C3_5EA1);
    // R5 matching address during DMA cycle
    io_write({base_sw, 2'd2}, 8'h00, 1'b0, "R5");
    check("R5", port_q, 32'hD4C3_5EA1);
    // R8 move the base
    base_sw = 14'h0311;
    io_write({14'h00C0, 2'd0}, 8'h77, 1'b1, "R8");
    io_write({14'h0311, 2'd0}, 8'h99, 1'b1, "R8");
    check("R8", port_q, 32'hD4C3_5E99);
    // random mix, half aimed at the base (R7 scrambling inside io_write)
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(1, 0) == 1) a[15:2] = base_sw;
      io_write(a, 8'($urandom), ($urandom_range(7, 0) != 0), "R7");
    end
    finish_run();
  end
endmodule